// File: doc/BRIEF.md
# Channel Event Status Unit

This unit keeps the pending-event state behind a processor's event channels. Other units raise single-cycle event pulses (one of them a reservation-lost indication) that accumulate as sticky bits in a status register. Software writes a mask register and acknowledges events through channel writes. It reads back the masked status, the mask and a machine-status word that carries the interrupt-enable state. A count output tells the processor whether a status read would return at once.

A status read with no masked event pending does not return. It raises a waiting flag and stays outstanding until a masked event appears, then completes with the masked status and drops the flag. While the flag is up, any event bit that goes from clear to set produces a one-cycle wake-up pulse, so a sleeping core can be woken. Channel writes that carry unimplemented event bits are refused, and so is a nonzero mask while interrupts are enabled. A refused write leaves all state as it was and raises a one-cycle error pulse. Interrupt delivery is handled elsewhere.

Top module: `evt_chan_unit`

## Requirements
- R1: After reset the status, mask, waiting flag and interrupt enable are zero, and ch_rd_valid_o, ch_cnt_o, wait_o, wake_o and err_o are low.
- R2: A high bit of evt_set_i, or rsv_lost_i for bit RSV_BIT, sets that status bit at the next clock edge if the bit is in IMPL_MASK. Lines outside IMPL_MASK are ignored. A set and an acknowledge of the same bit in one cycle leave the bit set.
- R3: A channel write with ch_wr_sel_i=1 (acknowledge) clears the written bits from the status. If it carries any bit outside IMPL_MASK, the write is refused.
- R4: A channel write with ch_wr_sel_i=0 (mask) replaces the stored mask. If it carries any bit outside IMPL_MASK, the write is refused.
- R5: A nonzero mask write while the interrupt enable is set is refused. A zero mask write is still accepted. The interrupt enable takes intr_en_val_i at the clock edge where intr_en_wr_i is high.
- R6: ch_cnt_o is 1 exactly when status AND mask is nonzero.
- R7: A status read (ch_rd_sel_i=0) with a masked event pending raises ch_rd_valid_o for one cycle, one cycle after the request, with data equal to status AND mask.
- R8: A status read with nothing masked pending sets wait_o at the next edge and gives no valid response. Other read requests are ignored while wait_o is high. One cycle after a masked event is present in the status, ch_rd_valid_o rises with status AND mask and wait_o falls.
- R9: wake_o pulses in the cycle after an edge where a set pulse hits a status bit that was clear while wait_o was high. A set on an already-set bit, or any set while wait_o is low, gives no pulse.
- R10: A mask read (ch_rd_sel_i=1) returns the stored mask. A machine-status read (ch_rd_sel_i=2) returns the interrupt enable in bit 0 and zeros above it. Select 3 returns zero. All three respond one cycle after the request.
- R11: err_o pulses for one cycle after each refused write. A refused write changes neither status nor mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_set_i | input | EVT_W | Event set pulses |
| rsv_lost_i | input | 1 | Reservation-lost pulse, sets bit RSV_BIT |
| intr_en_wr_i | input | 1 | Load interrupt enable |
| intr_en_val_i | input | 1 | New interrupt enable value |
| ch_wr_i | input | 1 | Channel write strobe |
| ch_wr_sel_i | input | 1 | 0 mask, 1 acknowledge |
| ch_wr_data_i | input | EVT_W | Channel write data |
| ch_rd_i | input | 1 | Channel read request |
| ch_rd_sel_i | input | 2 | 0 status, 1 mask, 2 machine status |
| ch_rd_valid_o | output | 1 | Read response valid |
| ch_rd_data_o | output | EVT_W | Read response data |
| ch_cnt_o | output | 1 | Status channel count |
| wait_o | output | 1 | Blocking status read outstanding |
| wake_o | output | 1 | Wake-up pulse |
| err_o | output | 1 | Refused write pulse |

## Verification
The bench builds the unit with EVT_W=4, IMPL_MASK=4'b1011 and RSV_BIT=3. One bit is left unimplemented, so refusal of writes and the ignoring of set lines can be seen. Four bits also allow every mask value to be swept against every set pattern, and every acknowledge value to be swept against a full status. Blocking reads are then run to check the order of the wake pulse and the completion when unmasked and masked events arrive.

// File: rtl/evt_pkg.sv
package evt_pkg;
  typedef enum logic {
    WR_MASK = 1'b0,
    WR_ACK  = 1'b1
  } wr_sel_e;

  typedef enum logic [1:0] {
    RD_STAT = 2'd0,
    RD_MASK = 2'd1,
    RD_MACH = 2'd2,
    RD_NONE = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/evt_status_reg.sv
module evt_status_reg #(
  parameter int               EVT_W     = 16,
  parameter logic [EVT_W-1:0] IMPL_MASK = '1,
  parameter int               RSV_BIT   = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_W-1:0] evt_set_i,
  input  logic             rsv_lost_i,
  input  logic             ack_en_i,
  input  logic [EVT_W-1:0] ack_bits_i,
  input  logic             waiting_i,
  output logic [EVT_W-1:0] stat_o,
  output logic             wake_o
);
  logic [EVT_W-1:0] rsv_v, set_v, stat_q, ack_v;
  logic             wake_q;

  generate
    for (genvar i = 0; i < EVT_W; i++) begin : g_rsv
      if (i == RSV_BIT) begin : g_hit
        assign rsv_v[i] = rsv_lost_i;
      end else begin : g_miss
        assign rsv_v[i] = 1'b0;
      end
    end
  endgenerate

  assign set_v = (evt_set_i | rsv_v) & IMPL_MASK;
  assign ack_v = ack_en_i ? ack_bits_i : '0;

  // set wins over a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      wake_q <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~ack_v) | set_v;
      wake_q <= waiting_i && |(set_v & ~stat_q);
    end
  end

  assign stat_o = stat_q;
  assign wake_o = wake_q;

  assert_set_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_v) |=> ((stat_q & $past(set_v)) == $past(set_v)));
  assert_ack_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_en_i |=> ((stat_q & $past(ack_bits_i & ~set_v)) == '0));
  assert_stat_impl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q & ~IMPL_MASK) == '0);
  assert_wake_needs_wait_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_q |-> $past(waiting_i));
endmodule

// File: rtl/evt_cfg_ctrl.sv
module evt_cfg_ctrl
  import evt_pkg::*;
#(
  parameter int               EVT_W     = 16,
  parameter logic [EVT_W-1:0] IMPL_MASK = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ch_wr_i,
  input  logic             ch_wr_sel_i,
  input  logic [EVT_W-1:0] ch_wr_data_i,
  input  logic             intr_en_wr_i,
  input  logic             intr_en_val_i,
  output logic [EVT_W-1:0] mask_o,
  output logic             ien_o,
  output logic             ack_en_o,
  output logic [EVT_W-1:0] ack_bits_o,
  output logic             err_o
);
  wr_sel_e          sel;
  logic             stray, bad, mask_wr;
  logic [EVT_W-1:0] mask_q;
  logic             ien_q, err_q;

  assign sel     = wr_sel_e'(ch_wr_sel_i);
  assign stray   = |(ch_wr_data_i & ~IMPL_MASK);
  assign bad     = stray || (sel == WR_MASK && ien_q && |ch_wr_data_i);
  assign mask_wr = ch_wr_i && sel == WR_MASK && !bad;

  assign ack_en_o   = ch_wr_i && sel == WR_ACK && !bad;
  assign ack_bits_o = ch_wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      ien_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (mask_wr)      mask_q <= ch_wr_data_i;
      if (intr_en_wr_i) ien_q  <= intr_en_val_i;
      err_q <= ch_wr_i && bad;
    end
  end

  assign mask_o = mask_q;
  assign ien_o  = ien_q;
  assign err_o  = err_q;

  assert_err_from_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> $past(ch_wr_i));
  assert_err_keeps_mask_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> $stable(mask_q));
  assert_mask_impl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q & ~IMPL_MASK) == '0);
  assert_ien_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q && $past(ien_q) && !$stable(mask_q)) |-> (mask_q == '0));
endmodule

// File: rtl/evt_rd_ctrl.sv
module evt_rd_ctrl
  import evt_pkg::*;
#(
  parameter int EVT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ch_rd_i,
  input  logic [1:0]       ch_rd_sel_i,
  input  logic [EVT_W-1:0] stat_i,
  input  logic [EVT_W-1:0] mask_i,
  input  logic             ien_i,
  output logic             valid_o,
  output logic [EVT_W-1:0] data_o,
  output logic             waiting_o
);
  rd_sel_e          sel;
  logic [EVT_W-1:0] pend;
  logic             valid_q, waiting_q;
  logic [EVT_W-1:0] data_q;

  assign sel  = rd_sel_e'(ch_rd_sel_i);
  assign pend = stat_i & mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      waiting_q <= 1'b0;
      data_q    <= '0;
    end else begin
      valid_q <= 1'b0;
      if (waiting_q) begin
        if (|pend) begin
          valid_q   <= 1'b1;
          data_q    <= pend;
          waiting_q <= 1'b0;
        end
      end else if (ch_rd_i) begin
        unique case (sel)
          RD_STAT: begin
            if (|pend) begin
              valid_q <= 1'b1;
              data_q  <= pend;
            end else begin
              waiting_q <= 1'b1;
            end
          end
          RD_MASK: begin
            valid_q <= 1'b1;
            data_q  <= mask_i;
          end
          RD_MACH: begin
            valid_q <= 1'b1;
            data_q  <= {{(EVT_W-1){1'b0}}, ien_i};
          end
          default: begin
            valid_q <= 1'b1;
            data_q  <= '0;
          end
        endcase
      end
    end
  end

  assign valid_o   = valid_q;
  assign data_o    = data_q;
  assign waiting_o = waiting_q;

  assert_no_valid_while_wait_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    waiting_q |-> !valid_q);
  assert_wake_done_nonzero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && $past(waiting_q)) |-> (|data_q));
  assert_wait_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(waiting_q) |-> valid_q);
  assert_valid_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ch_rd_i) |=> !valid_q);
endmodule

// File: rtl/evt_chan_unit.sv
module evt_chan_unit #(
  parameter int               EVT_W     = 16,
  parameter logic [EVT_W-1:0] IMPL_MASK = 16'h0F7F,
  parameter int               RSV_BIT   = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_W-1:0] evt_set_i,
  input  logic             rsv_lost_i,
  input  logic             intr_en_wr_i,
  input  logic             intr_en_val_i,
  input  logic             ch_wr_i,
  input  logic             ch_wr_sel_i,
  input  logic [EVT_W-1:0] ch_wr_data_i,
  input  logic             ch_rd_i,
  input  logic [1:0]       ch_rd_sel_i,
  output logic             ch_rd_valid_o,
  output logic [EVT_W-1:0] ch_rd_data_o,
  output logic             ch_cnt_o,
  output logic             wait_o,
  output logic             wake_o,
  output logic             err_o
);
  logic [EVT_W-1:0] stat, mask, ack_bits;
  logic             ien, ack_en, waiting;

  evt_cfg_ctrl #(.EVT_W(EVT_W), .IMPL_MASK(IMPL_MASK)) cfg_i (
    .clk_i, .rst_ni, .ch_wr_i, .ch_wr_sel_i, .ch_wr_data_i,
    .intr_en_wr_i, .intr_en_val_i,
    .mask_o(mask), .ien_o(ien), .ack_en_o(ack_en), .ack_bits_o(ack_bits), .err_o
  );

  evt_status_reg #(.EVT_W(EVT_W), .IMPL_MASK(IMPL_MASK), .RSV_BIT(RSV_BIT)) stat_i (
    .clk_i, .rst_ni, .evt_set_i, .rsv_lost_i,
    .ack_en_i(ack_en), .ack_bits_i(ack_bits), .waiting_i(waiting),
    .stat_o(stat), .wake_o
  );

  evt_rd_ctrl #(.EVT_W(EVT_W)) rd_i (
    .clk_i, .rst_ni, .ch_rd_i, .ch_rd_sel_i,
    .stat_i(stat), .mask_i(mask), .ien_i(ien),
    .valid_o(ch_rd_valid_o), .data_o(ch_rd_data_o), .waiting_o(waiting)
  );

  assign ch_cnt_o = |(stat & mask);
  assign wait_o   = waiting;

  assert_cnt_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_o && !ch_cnt_o) |=> !ch_rd_valid_o);
endmodule

// File: tb/evt_chan_unit_tb.sv
module evt_chan_unit_tb_top;
  localparam int         CLK_PERIOD = 10;
  localparam int         W    = 4;
  localparam logic [3:0] IMPL = 4'b1011;
  localparam int         RSV  = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] evt_set = '0, wr_data = '0;
  logic rsv_lost = 0, ien_wr = 0, ien_val = 0, wr = 0, wr_sel = 0, rd = 0;
  logic [1:0] rd_sel = '0;
  logic rd_valid, cnt, wt, wake, err;
  logic [W-1:0] rd_data;

  int checks = 0, errors = 0;
  logic [W-1:0] m_stat = '0, m_mask = '0;
  logic m_ien = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_chan_unit #(.EVT_W(W), .IMPL_MASK(IMPL), .RSV_BIT(RSV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_set_i(evt_set), .rsv_lost_i(rsv_lost),
    .intr_en_wr_i(ien_wr), .intr_en_val_i(ien_val),
    .ch_wr_i(wr), .ch_wr_sel_i(wr_sel), .ch_wr_data_i(wr_data),
    .ch_rd_i(rd), .ch_rd_sel_i(rd_sel),
    .ch_rd_valid_o(rd_valid), .ch_rd_data_o(rd_data), .ch_cnt_o(cnt),
    .wait_o(wt), .wake_o(wake), .err_o(err)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic do_wr(logic sel, logic [W-1:0] d, string req);
    logic bad;
    bad = |(d & ~IMPL) || (sel == 1'b0 && m_ien && |d);
    wr = 1; wr_sel = sel; wr_data = d;
    cyc();
    wr = 0;
    chk(req, err, bad);
    if (!bad) begin
      if (sel) m_stat = m_stat & ~d;
      else     m_mask = d;
    end
  endtask

  task automatic do_set(logic [W-1:0] s, logic r);
    evt_set = s; rsv_lost = r;
    cyc();
    evt_set = '0; rsv_lost = 0;
    m_stat = m_stat | ((s | (r ? 4'b1000 : 4'b0)) & IMPL);
  endtask

  task automatic do_rd(logic [1:0] sel, int exp, string req);
    rd = 1; rd_sel = sel;
    cyc();
    rd = 0;
    chk(req, rd_valid, 1);
    chk(req, rd_data, exp);
  endtask

  task automatic chk_stat(string req);
    logic [W-1:0] keep;
    keep = m_mask;
    do_wr(1'b0, IMPL, req);
    chk(req, cnt, m_stat != 0);
    if (m_stat != 0) do_rd(2'd0, m_stat, req);
    do_wr(1'b0, keep, req);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    // R1 reset state
    chk("R1 valid", rd_valid, 0); chk("R1 cnt", cnt, 0); chk("R1 wait", wt, 0);
    chk("R1 wake", wake, 0); chk("R1 err", err, 0);
    rst_n = 1; cyc();
    do_rd(2'd1, 0, "R1 mask");
    do_rd(2'd2, 0, "R1 mach");

    // R4 R6 R7: every mask against every set pattern
    for (int m = 0; m < 16; m++) begin
      for (int s = 0; s < 16; s++) begin
        do_wr(1'b1, IMPL, "R3 clear");
        do_wr(1'b0, m[3:0], "R4 mask write");
        do_rd(2'd1, m_mask, "R4 mask read");
        do_set(s[3:0], 1'b0);
        chk("R6 count", cnt, (m_stat & m_mask) != 0);
        if ((m_stat & m_mask) != 0) do_rd(2'd0, m_stat & m_mask, "R7 status read");
      end
    end

    // R3 R11: every acknowledge value against a full status
    for (int a = 0; a < 16; a++) begin
      do_set(4'hF, 1'b1);
      do_wr(1'b1, a[3:0], "R3 ack");
      if (err) begin
        cyc();
        chk("R11 err single", err, 0);
      end
      chk_stat("R3 R11 status after ack");
    end

    // R2 unimplemented line, reservation lost, set beats ack
    do_wr(1'b1, IMPL, "R3 clear");
    do_set(4'b0100, 1'b0);
    chk_stat("R2 unimpl ignored");
    do_set(4'b0000, 1'b1);
    chk_stat("R2 rsv lost");
    evt_set = 4'b0001; wr = 1; wr_sel = 1; wr_data = 4'b1001;
    cyc();
    evt_set = '0; wr = 0;
    m_stat = 4'b0001;
    chk_stat("R2 set wins");

    // R5 R10 interrupt enable
    do_wr(1'b0, 4'b0011, "R4 mask");
    ien_wr = 1; ien_val = 1; cyc(); ien_wr = 0; m_ien = 1;
    do_rd(2'd2, 1, "R10 mach on");
    do_wr(1'b0, 4'b0001, "R5 nonzero refused");
    do_rd(2'd1, 4'b0011, "R5 mask kept");
    do_wr(1'b0, 4'b0000, "R5 zero accepted");
    do_rd(2'd1, 0, "R5 mask zero");
    ien_wr = 1; ien_val = 0; cyc(); ien_wr = 0; m_ien = 0;
    do_rd(2'd2, 0, "R10 mach off");
    do_rd(2'd3, 0, "R10 reserved");

    // R8 R9 blocking read
    do_wr(1'b1, IMPL, "R3 clear");
    do_wr(1'b0, 4'b0001, "R4 mask");
    do_set(4'b0010, 1'b0);
    chk("R9 no wake idle", wake, 0);
    rd = 1; rd_sel = 2'd0; cyc(); rd = 0;
    chk("R8 wait set", wt, 1); chk("R8 no valid", rd_valid, 0);
    rd = 1; rd_sel = 2'd1; cyc(); rd = 0;
    chk("R8 other read ignored", rd_valid, 0);
    do_set(4'b0010, 1'b0);
    chk("R9 no wake already set", wake, 0);
    do_set(4'b1000, 1'b0);
    chk("R9 wake unmasked", wake, 1);
    cyc();
    chk("R9 wake pulse", wake, 0); chk("R8 still waiting", wt, 1);
    do_set(4'b0001, 1'b0);
    chk("R9 wake masked", wake, 1); chk("R8 not yet valid", rd_valid, 0);
    cyc();
    chk("R8 valid", rd_valid, 1); chk("R8 data", rd_data, 4'b0001);
    chk("R8 wait clear", wt, 0);
    do_set(4'b0000, 1'b1);
    chk("R9 no wake after", wake, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule